// File: doc/BRIEF.md
# Fractional-Timing UART Receiver

This block recovers 8-bit asynchronous serial frames from a single receive line. It runs on a fast sampling clock that is not tied to the baud rate. The nominal bit slot in sampling clocks comes from an integer divider. A correction mask with one bit per frame slot lengthens the chosen slots by one clock each. When the clock-to-baud ratio has a fractional part, setting that proportion of mask bits, spread evenly across the frame, keeps the average slot length close to the true bit period. For example, a ratio of 8.25 uses a divider of 8 with about a quarter of the mask bits set.

A frame starts on a falling edge of the receive line, seen after a two-stage synchroniser. The slot counter is then preloaded with 3 so that the synchroniser and edge-detector latency is already counted. Each slot is sampled near its centre. The start bit is checked to reject glitches. The data bits arrive least-significant first. One or two stop bits are then checked. The result appears as a byte with a one-cycle valid strobe, plus a framing-error flag that is raised in the same cycle when a stop bit is low.

Top module: `frac_uart_rx`

## Requirements
- R1: While reset is asserted and right after its release, `valid_o` and `frame_err_o` are 0 and `data_o` is 0.
- R2: A falling edge on `rx_i` starts a frame. Let k be the first rising clock edge at which the new low level is sampled. The counter reaches 3 in start slot 0 at edge k+2.
- R3: Slot i (0 = start, 1..8 = data bits 0..7, 9 = first stop, 10 = second stop) lasts `div_i + corr_mask_i[i]` sampling clocks.
- R4: Each slot is sampled when its counter equals `div_i/2` (integer division). In the start slot the sample point is never earlier than count 3. As a result, `valid_o` rises after edge k + L0 + (L1 + ... + L(last-1)) + div_i/2, where Li is the length of slot i and "last" is the final stop slot.
- R5: Data bits are shifted in least-significant bit first: slot 1 becomes `data_o[0]` and slot 8 becomes `data_o[7]`.
- R6: `valid_o` is high for exactly one clock per frame. `data_o` holds the last received byte until the next frame completes.
- R7: With `two_stop_i` = 0 the frame ends at the slot-9 sample. With `two_stop_i` = 1 the frame also samples slot 10, and the length of slot 9 adds to the completion time.
- R8: If the start slot is sampled high, the event is treated as a glitch. The receiver returns to idle with no strobe, and `data_o` is left unchanged.
- R9: If any configured stop bit is sampled low, `frame_err_o` is 1 in the same cycle as `valid_o`. The receiver then waits for the line to be high before it can detect a new start.
- R10: After a clean frame the receiver is armed at the last stop sample, so a start edge at the very end of the stop slot is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Raw serial receive line, idle high |
| div_i | input | DIV_W | Integer part of sampling-clock-to-baud ratio |
| corr_mask_i | input | DATA_W+3 | One-clock extension per frame slot, index 0 = start |
| two_stop_i | input | 1 | 1 selects two stop bits |
| data_o | output | DATA_W | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a completed frame |
| frame_err_o | output | 1 | Stop bit sampled low, qualified by valid_o |

## Verification
The assertions assume that `div_i` is at least 4, and that `div_i`, `corr_mask_i` and `two_stop_i` stay constant from a start edge until the frame strobe. The slot-length bound and the stop-slot check depend on that. The stimulus changes configuration only between frames, while the line is idle. Every bit it drives lasts exactly the programmed slot length, including the mask extension, so the bench can predict the completion cycle from the slot lengths alone.

// File: rtl/frac_rx_pkg.sv
package frac_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RECV      = 2'd1,
    ST_WAIT_HIGH = 2'd2
  } rx_state_e;

  // counter value loaded at start detection (covers sync + edge latency)
  localparam int unsigned START_PRELOAD = 3;

endpackage

// File: rtl/rx_sync_fall.sv
module rx_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_sync_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= rx_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign rx_sync_o = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= rx_sync_o;
  end

  assign fall_o = prev_q & ~rx_sync_o;

endmodule

// File: rtl/rx_slot_timer.sv
module rx_slot_timer
  import frac_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned NSLOT = 11,
  parameter int unsigned IDX_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [NSLOT-1:0] mask_i,
  output logic             sample_o,
  output logic [IDX_W-1:0] slot_o
);

  localparam int unsigned CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] PRELOAD = CNT_W'(START_PRELOAD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0] slot_len, half, samp_pt;
  logic             ext, wrap, cnt_en;

  assign ext      = (slot_q < IDX_W'(NSLOT)) ? mask_i[slot_q] : 1'b0;
  assign slot_len = {1'b0, div_i} + CNT_W'(ext);
  assign half     = {2'b00, div_i[DIV_W-1:1]};
  assign samp_pt  = ((slot_q == '0) && (half < PRELOAD)) ? PRELOAD : half;
  assign wrap     = (cnt_q == slot_len - CNT_W'(1));
  assign sample_o = run_i && (cnt_q == samp_pt);
  assign slot_o   = slot_q;
  assign cnt_en   = start_i | run_i;

  always_comb begin
    cnt_d  = cnt_q;
    slot_d = slot_q;
    if (start_i) begin
      cnt_d  = PRELOAD;
      slot_d = '0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_d  = '0;
        slot_d = slot_q + IDX_W'(1);
      end else begin
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  // R3: the counter never runs past the stretched slot length
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < slot_len));

  // R2: a start always lands on the preload value
  a_r2_preload: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == PRELOAD && slot_q == '0));

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import frac_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              rx_i,
  input  logic              sample_i,
  input  logic [IDX_W-1:0]  slot_i,
  input  logic              two_stop_i,
  output logic              start_o,
  output logic              run_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o
);

  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] STOP1     = IDX_W'(DATA_W + 2);

  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] shift_q, shift_d, data_q, data_d;
  logic              err_q, err_d, valid_q, valid_d, ferr_q, ferr_d;
  logic              fin, bad;

  always_comb begin
    state_d = state_q;
    shift_d = shift_q;
    data_d  = data_q;
    err_d   = err_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    start_o = 1'b0;
    fin     = 1'b0;
    bad     = err_q | ~rx_i;
    unique case (state_q)
      ST_IDLE: begin
        if (fall_i) begin
          start_o = 1'b1;
          err_d   = 1'b0;
          state_d = ST_RECV;
        end
      end
      ST_RECV: begin
        if (sample_i) begin
          if (slot_i == '0) begin
            if (rx_i) state_d = ST_IDLE;
          end else if (slot_i <= LAST_DATA) begin
            shift_d = {rx_i, shift_q[DATA_W-1:1]};
          end else begin
            fin   = (slot_i == STOP1) || !two_stop_i;
            err_d = bad;
            if (fin) begin
              data_d  = shift_q;
              valid_d = 1'b1;
              ferr_d  = bad;
              state_d = bad ? ST_WAIT_HIGH : ST_IDLE;
            end
          end
        end
      end
      ST_WAIT_HIGH: begin
        if (rx_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shift_q <= shift_d;
      data_q  <= data_d;
      err_q   <= err_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign run_o   = (state_q == ST_RECV);
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;

  // R6: strobe lasts a single cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R9: error flag only accompanies a strobe
  a_r9_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q |-> valid_q);

  // R7: the second stop slot is only sampled when two stops are selected
  a_r7_second_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV && sample_i && slot_i == STOP1) |-> two_stop_i);

  // R10: a clean frame leaves the receiver armed
  a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ferr_q) |-> (state_q == ST_IDLE));

endmodule

// File: rtl/frac_uart_rx.sv
module frac_uart_rx #(
  parameter int unsigned DIV_W       = 12,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W+2:0] corr_mask_i,
  input  logic              two_stop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o
);

  localparam int unsigned NSLOT = DATA_W + 3;
  localparam int unsigned IDX_W = $clog2(NSLOT);

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic             rx_sync, fall, start, run, sample;
  logic [IDX_W-1:0] slot;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  rx_sync_fall #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rx_i      (rx_i),
    .rx_sync_o (rx_sync),
    .fall_o    (fall)
  );

  rx_slot_timer #(
    .DIV_W (DIV_W),
    .NSLOT (NSLOT),
    .IDX_W (IDX_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start_i  (start),
    .run_i    (run),
    .div_i    (div_i),
    .mask_i   (corr_mask_i),
    .sample_o (sample),
    .slot_o   (slot)
  );

  rx_frame_ctrl #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fall_i     (fall),
    .rx_i       (rx_sync),
    .sample_i   (sample),
    .slot_i     (slot),
    .two_stop_i (two_stop_i),
    .start_o    (start),
    .run_o      (run),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .ferr_o     (frame_err_o)
  );

endmodule

// File: tb/test_frac_uart_rx.sv
module test_frac_uart_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [11:0] div = 12'd8;
  logic [10:0] mask = '0;
  logic        two = 1'b0;
  logic [7:0]  data;
  logic        valid, ferr;

  int cyc = 0;
  int total = 0;
  int fails = 0;
  int n_valid = 0;
  int last_cyc = 0;
  logic [7:0] last_data = '0;
  logic       last_ferr = 1'b0;
  bit done = 0;

  frac_uart_rx i_frac_uart_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_i        (rx),
    .div_i       (div),
    .corr_mask_i (mask),
    .two_stop_i  (two),
    .data_o      (data),
    .valid_o     (valid),
    .frame_err_o (ferr)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (valid) begin
      n_valid   <= n_valid + 1;
      last_cyc  <= cyc;
      last_data <= data;
      last_ferr <= ferr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives one frame with exact slot lengths; returns the cycle of the falling edge
  task automatic drive_frame(input logic [7:0] d, input bit [1:0] bad, output int c0);
    int last;
    last = two ? 10 : 9;
    for (int i = 0; i <= last; i++) begin
      @(negedge clk);
      if (i == 0) begin
        rx = 1'b0;
        c0 = cyc;
      end else if (i <= 8) rx = d[i-1];
      else if (i == 9) rx = ~bad[0];
      else rx = ~bad[1];
      repeat (int'(div) + int'(mask[i]) - 1) @(negedge clk);
    end
    @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic run_frame(input int dv, input logic [10:0] mk, input bit tw,
                           input logic [7:0] d, input bit [1:0] bad, input int tail,
                           input string tag);
    int c0, nv0, exp, last;
    bit ef;
    div  = 12'(dv);
    mask = mk;
    two  = tw;
    nv0  = n_valid;
    drive_frame(d, bad, c0);
    repeat (tail) @(negedge clk);
    #1;
    last = tw ? 10 : 9;
    exp  = c0 + 1 + dv / 2;
    for (int i = 0; i < last; i++) exp += dv + int'(mk[i]);
    ef = bad[0] | (tw & bad[1]);
    chk(n_valid == nv0 + 1, {tag, " R6 one strobe"}, n_valid - nv0, 1);
    chk(last_data == d, {tag, " R5 data"}, last_data, d);
    chk(last_ferr == ef, {tag, " R9 frame error"}, last_ferr, ef);
    chk(last_cyc == exp, {tag, " R2 R3 R4 completion cycle"}, last_cyc, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(valid == 1'b0 && ferr == 1'b0 && data == 8'h00, "R1 in reset", {data, valid, ferr}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(valid == 1'b0 && ferr == 1'b0 && data == 8'h00, "R1 after release", {data, valid, ferr}, 0);
  endtask

  task automatic t_basic;
    run_frame(8, 11'h000, 1'b0, 8'h35, 2'b00, 30, "basic");
    chk(data == 8'h35, "R6 data held", data, 8'h35);
    run_frame(8, 11'h000, 1'b0, 8'hFF, 2'b00, 30, "ones");
    run_frame(8, 11'h000, 1'b0, 8'h00, 2'b00, 30, "zeros");
  endtask

  task automatic t_fraction;
    run_frame(9, 11'b010_0100_1010, 1'b1, 8'hA6, 2'b00, 30, "R3 fraction two-stop");
    run_frame(8, 11'b000_0000_0010, 1'b0, 8'h5A, 2'b00, 30, "R3 mask slot1");
    run_frame(8, 11'b010_0000_0000, 1'b1, 8'h81, 2'b00, 30, "R7 mask slot9");
  endtask

  task automatic t_small_div;
    run_frame(5, 11'b000_1000_0001, 1'b0, 8'hC9, 2'b00, 30, "R4 odd div");
    run_frame(4, 11'h000, 1'b0, 8'h3C, 2'b00, 30, "R4 div4");
  endtask

  task automatic t_glitch;
    int nv0;
    div = 12'd8; mask = '0; two = 1'b0;
    nv0 = n_valid;
    @(negedge clk); rx = 1'b0;
    @(negedge clk); rx = 1'b1;
    repeat (120) @(negedge clk);
    chk(n_valid == nv0, "R8 glitch no strobe", n_valid - nv0, 0);
    chk(data == 8'h3C, "R8 data unchanged", data, 8'h3C);
    run_frame(8, 11'h000, 1'b0, 8'h96, 2'b00, 30, "R8 after glitch");
  endtask

  task automatic t_ferr;
    int nv0;
    run_frame(8, 11'h000, 1'b0, 8'h4B, 2'b01, 0, "R9 bad stop");
    nv0 = n_valid;
    // keep line low past the stop slot, then release
    rx = 1'b0;
    repeat (40) @(negedge clk);
    rx = 1'b1;
    repeat (20) @(negedge clk);
    chk(n_valid == nv0, "R9 no strobe while low", n_valid - nv0, 0);
    run_frame(8, 11'h000, 1'b1, 8'h2D, 2'b10, 30, "R9 bad second stop");
    run_frame(8, 11'h000, 1'b0, 8'h77, 2'b00, 30, "R9 recovered");
  endtask

  task automatic t_back2back;
    run_frame(8, 11'b001_0001_0000, 1'b1, 8'hE1, 2'b00, 0, "R10 first");
    run_frame(8, 11'b001_0001_0000, 1'b1, 8'h1E, 2'b00, 0, "R10 second");
    run_frame(8, 11'b001_0001_0000, 1'b0, 8'h69, 2'b00, 30, "R10 third");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fraction();
    t_small_div();
    t_glitch();
    t_ferr();
    t_back2back();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule